// File: doc/BRIEF.md
# Three-Level PWM Gate Sequencer

This block controls the two switches of a synchronous buck stage from a clocked digital domain. It takes a decoded three-level PWM command and produces a high-side and a low-side gate request. A high command selects the high-side switch and a low command selects the low-side switch. A mid command selects diode emulation. In diode emulation the low-side switch conducts until the inductor current reaches zero, and then it is released.

Dead time is adaptive and has no fixed delay. Before a gate is requested on, the opposite gate must already be requested off, and its digitized feedback must report that its voltage is below the turn-off point. A new command simply re-sequences from the present gate state, so a turn-on that is still pending when the command changes is dropped. A supervisor enable forces both requests off.

Top module: `pwm_gate_seq`

## Requirements
- R1: With enable high and the level code 10 (high) held, the steady state is `hs_on_o`=1 and `ls_on_o`=0.
- R2: With enable high and the level code 00 (low) held, the steady state is `hs_on_o`=0 and `ls_on_o`=1.
- R3: On a change to high, `ls_on_o` falls at the next clock edge. `hs_on_o` rises only at an edge where `ls_on_o` was already 0 and `ls_low_i` was 1. It waits for as long as `ls_low_i` stays 0.
- R4: On a change to low, `hs_on_o` falls at the next clock edge. `ls_on_o` rises only at an edge where `hs_on_o` was already 0 and `hs_low_i` was 1. It waits for as long as `hs_low_i` stays 0.
- R5: In the mid level, `hs_on_o` is 0. `ls_on_o` turns on under the same non-overlap condition as R4.
- R6: In the mid level, `zc_i` is ignored during the first BLANK_CYC+DEB_CYC cycles that `ls_on_o` is high. If `zc_i` is held at 1, `ls_on_o` stays high for exactly BLANK_CYC+DEB_CYC+1 cycles (34 with the defaults). Without `zc_i`, `ls_on_o` stays high.
- R7: In the mid level, `zc_i` sampled after the window turns `ls_on_o` off at the next edge. It then stays off while the level remains mid, whatever `zc_i` does. Leaving mid clears this state.
- R8: While `rst_ni` is low, both outputs are 0. When `en_i` is 0 at an edge, both outputs are 0 after that edge, regardless of the level code.
- R9: `hs_on_o` and `ls_on_o` are never 1 in the same cycle.
- R10: If the command changes while a turn-on is still pending, that turn-on never happens, and the new command is sequenced from the current outputs.
- R11: The level code is decoded as 00 = low, 01 = mid and 10 = high. Code 11 behaves exactly as mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Supervisor enable |
| pwm_lvl_i | input | 2 | PWM level code (00 low, 01 mid, 10 high, 11 mid) |
| hs_low_i | input | 1 | High-side gate-to-switch voltage is below 1 V |
| ls_low_i | input | 1 | Low-side gate voltage is below 1 V |
| zc_i | input | 1 | Zero-cross comparator flag |
| hs_on_o | output | 1 | High-side gate request |
| ls_on_o | output | 1 | Low-side gate request |

## Verification
The bench holds the gate feedback low for several cycles after a command change. A design that ran a fixed dead time instead of waiting for the feedback would turn the second gate on early.

It reverses a command while a turn-on is still pending. A design that latched the pending turn-on would pulse the wrong gate or overlap the two gates.

In diode emulation, the bench holds the zero-cross flag from the very first cycle, and separately pulses it inside the window. This catches a window that is off by one cycle or ignored altogether, since the low-side on-time would differ from 34 cycles or end too early.

It also drops the flag after the release, and sends code 11. A design that re-armed the low-side gate, or decoded 11 as high, would fail those checks.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'd0,
    CMD_MID  = 2'd1,
    CMD_HIGH = 2'd2
  } pwm_cmd_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

endpackage

// File: rtl/pwm_lvl_decode.sv
module pwm_lvl_decode
  import pwm_gate_pkg::*;
(
  input  logic [1:0] lvl_i,
  output pwm_cmd_e   cmd_o
);

  // unused code 11 falls to mid: the safer of the two non-driving choices
  always_comb begin
    unique case (lvl_i)
      LVL_LOW:  cmd_o = CMD_LOW;
      LVL_HIGH: cmd_o = CMD_HIGH;
      default:  cmd_o = CMD_MID;
    endcase
  end

endmodule

// File: rtl/dem_window.sv
module dem_window #(
  parameter int unsigned BLANK_CYC = 25,
  parameter int unsigned DEB_CYC   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic open_o
);

  localparam int unsigned WIN = BLANK_CYC + DEB_CYC;
  localparam int unsigned CW  = (WIN < 2) ? 1 : $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WIN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != WIN_C) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = run_i && (cnt_q == WIN_C);

  // R6: the window may only open after a full run of WIN cycles
  p_win_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(run_i));

endmodule

// File: rtl/gate_core.sv
module gate_core
  import pwm_gate_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  pwm_cmd_e cmd_i,
  input  logic     hs_low_i,
  input  logic     ls_low_i,
  input  logic     zc_i,
  input  logic     win_open_i,
  output logic     win_run_o,
  output logic     hs_on_o,
  output logic     ls_on_o
);

  logic hs_q, ls_q, done_q;
  logic hs_d, ls_d, done_d;
  logic mid_now;

  assign mid_now = en_i && (cmd_i == CMD_MID);

  // next state from current outputs only: a changed command drops any pending turn-on
  always_comb begin
    hs_d   = 1'b0;
    ls_d   = 1'b0;
    done_d = 1'b0;
    if (en_i) begin
      unique case (cmd_i)
        CMD_HIGH: hs_d = hs_q || (!ls_q && ls_low_i);
        CMD_LOW:  ls_d = ls_q || (!hs_q && hs_low_i);
        default: begin
          if (done_q || (ls_q && win_open_i && zc_i)) done_d = 1'b1;
          else ls_d = ls_q || (!hs_q && hs_low_i);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      hs_q   <= hs_d;
      ls_q   <= ls_d;
      done_q <= done_d;
    end
  end

  assign win_run_o = mid_now && ls_q && !done_q;
  assign hs_on_o   = hs_q;
  assign ls_on_o   = ls_q;

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));

  p_en_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hs_q && !ls_q));

  p_hs_bbm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> ($past(ls_low_i) && !$past(ls_q) && $past(cmd_i) == CMD_HIGH));

  p_ls_bbm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) |-> ($past(hs_low_i) && !$past(hs_q)));

  p_done_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !ls_q);

  p_mid_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ls_q) && $past(mid_now)) |-> $past(win_open_i));

endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq
  import pwm_gate_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 25,
  parameter int unsigned DEB_CYC   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] pwm_lvl_i,
  input  logic       hs_low_i,
  input  logic       ls_low_i,
  input  logic       zc_i,
  output logic       hs_on_o,
  output logic       ls_on_o
);

  pwm_cmd_e cmd;
  logic     win_run, win_open;

  pwm_lvl_decode u_dec (
    .lvl_i (pwm_lvl_i),
    .cmd_o (cmd)
  );

  dem_window #(
    .BLANK_CYC (BLANK_CYC),
    .DEB_CYC   (DEB_CYC)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (win_run),
    .open_o (win_open)
  );

  gate_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cmd_i      (cmd),
    .hs_low_i   (hs_low_i),
    .ls_low_i   (ls_low_i),
    .zc_i       (zc_i),
    .win_open_i (win_open),
    .win_run_o  (win_run),
    .hs_on_o    (hs_on_o),
    .ls_on_o    (ls_on_o)
  );

  // R11: code 11 must never produce a high-side turn-on
  p_code11_mid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> ($past(pwm_lvl_i) == 2'b10));

endmodule

// File: tb/pwm_gate_seq_tb.sv
module pwm_gate_seq_tb;

  localparam int BLANK = 25;
  localparam int DEB   = 8;
  localparam int WIN   = BLANK + DEB;

  logic clk = 1'b0;
  logic rst_n, en, hs_low, ls_low, zc;
  logic [1:0] lvl;
  logic hs_on, ls_on;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  pwm_gate_seq #(.BLANK_CYC(BLANK), .DEB_CYC(DEB)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .pwm_lvl_i (lvl),
    .hs_low_i  (hs_low),
    .ls_low_i  (ls_low),
    .zc_i      (zc),
    .hs_on_o   (hs_on),
    .ls_on_o   (ls_on)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9 monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      checks++;
      if (hs_on && ls_on) begin
        errors++;
        $display("FAIL R9 overlap actual=%0d%0d expected=not both", hs_on, ls_on);
      end
    end
  end

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b1; lvl = 2'b00; hs_low = 1'b1; ls_low = 1'b1; zc = 1'b0;
    step(3);
    chk("R8", "reset hs", hs_on, 0);
    chk("R8", "reset ls", ls_on, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_low;
    step(1);
    chk("R2", "low ls", ls_on, 1);
    chk("R2", "low hs", hs_on, 0);
  endtask

  task automatic t_rise;
    lvl = 2'b10; ls_low = 1'b0;
    step(1);
    chk("R3", "ls off first", ls_on, 0);
    chk("R3", "hs waits", hs_on, 0);
    step(4);
    chk("R3", "hs waits for ls feedback", hs_on, 0);
    ls_low = 1'b1;
    step(1);
    chk("R1", "high hs", hs_on, 1);
    chk("R1", "high ls", ls_on, 0);
  endtask

  task automatic t_fall;
    lvl = 2'b00; hs_low = 1'b0;
    step(1);
    chk("R4", "hs off first", hs_on, 0);
    chk("R4", "ls waits", ls_on, 0);
    step(4);
    chk("R4", "ls waits for hs feedback", ls_on, 0);
    hs_low = 1'b1;
    step(1);
    chk("R2", "low ls after fall", ls_on, 1);
  endtask

  task automatic t_cancel;
    lvl = 2'b10; ls_low = 1'b0;
    step(3);
    chk("R10", "pending hs", hs_on, 0);
    lvl = 2'b00; ls_low = 1'b1;
    step(1);
    chk("R10", "cancelled hs", hs_on, 0);
    chk("R10", "ls re-sequenced", ls_on, 1);
    step(3);
    chk("R10", "hs stays off", hs_on, 0);
  endtask

  task automatic t_mid_zc(input logic [1:0] code, input string req);
    int n;
    lvl = 2'b10;
    step(2);
    chk(req, "pre high hs", hs_on, 1);
    lvl = code; hs_low = 1'b0; zc = 1'b1;
    step(1);
    chk("R5", "mid hs off", hs_on, 0);
    chk("R5", "mid ls waits", ls_on, 0);
    hs_low = 1'b1;
    step(1);
    chk("R5", "mid ls on", ls_on, 1);
    n = 1;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (ls_on !== 1'b1) break;
      n++;
    end
    chk(req, "mid ls on-time", n, WIN + 1);
    chk("R6", "on-time blank+deb+1", n, WIN + 1);
    zc = 1'b0;
    step(10);
    chk("R7", "ls stays off in mid", ls_on, 0);
    chk("R7", "hs stays off in mid", hs_on, 0);
    lvl = 2'b00;
    step(1);
    chk("R7", "zc state cleared by low", ls_on, 1);
  endtask

  task automatic t_mid_late;
    lvl = 2'b01; zc = 1'b1;
    step(5);
    zc = 1'b0;
    chk("R6", "zc in window ignored", ls_on, 1);
    step(60);
    chk("R6", "no zc holds ls", ls_on, 1);
    zc = 1'b1;
    step(1);
    chk("R7", "zc releases ls", ls_on, 0);
    zc = 1'b0;
    step(5);
    chk("R7", "ls stays off after zc", ls_on, 0);
    lvl = 2'b00;
    step(1);
    chk("R7", "low restores ls", ls_on, 1);
  endtask

  task automatic t_enable;
    lvl = 2'b10; en = 1'b0;
    step(1);
    chk("R8", "disabled hs", hs_on, 0);
    chk("R8", "disabled ls", ls_on, 0);
    step(5);
    chk("R8", "disabled hs held", hs_on, 0);
    en = 1'b1;
    step(1);
    chk("R1", "hs after enable", hs_on, 1);
  endtask

  initial begin
    #800us;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_low();
    t_rise();
    t_fall();
    t_cancel();
    t_mid_zc(2'b01, "R6");
    t_mid_zc(2'b11, "R11");
    t_mid_late();
    t_enable();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule